// File: doc/BRIEF.md
# 256-bit Shift and Rotate Execution Unit

This unit is the bit-movement slice of a stack-machine execution datapath. Each accepted operation presents an 8-bit opcode, a 256-bit amount and a 256-bit operand. The unit returns the operand moved by that amount as a logical left shift, a logical right shift, an arithmetic right shift, a left rotate or a right rotate. The result is registered and appears one clock after the input strobe, together with a valid flag and a flag that marks an unrecognised opcode.

The amount is treated as a full 256-bit unsigned number. The rule for an amount of 256 or more depends on the operation. Plain shifts give zero. The arithmetic shift gives copies of the sign bit. Rotates use the amount modulo 256, so they wrap and never wipe a nonzero operand. Internally, every operation runs through a single eight-stage logarithmic barrel that moves data right. Left operations bit-reverse the data before the barrel and again after it.

Top module: `shrot_unit`

## Requirements
- R1: Opcode 0x1b selects logical left shift, 0x1c logical right shift, 0x1d arithmetic right shift, 0x1e rotate left and 0x1f rotate right.
- R2: For logical left shift with amount n < 256, result equals value shifted left by n, with bits past bit 255 discarded and zeros entering at bit 0.
- R3: For logical right shift with amount n < 256, result equals value shifted right by n, with zeros entering at bit 255.
- R4: For arithmetic right shift with amount n < 256, value is read as signed two's complement and every vacated high bit takes the value of bit 255.
- R5: For logical left or right shift with amount ≥ 256, result is zero. This includes amounts whose low 8 bits are zero or small and whose only set bits lie in bits 255..8.
- R6: For arithmetic right shift with amount ≥ 256, result is all ones when bit 255 of value is 1 and all zeros otherwise.
- R7: Rotates move value by (amount mod 256). Bits 255..8 of the amount have no effect, no bit is lost, and the population count of result equals that of value.
- R8: An amount of zero returns value unchanged for all five operations.
- R9: Any opcode outside 0x1b..0x1f gives result zero with illegal high in the same output cycle.
- R10: out_valid is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, result and illegal keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 8 | Operation select |
| index | input | 256 | Shift or rotate amount, unsigned |
| value | input | 256 | Operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 256 | Registered result |
| illegal | output | 1 | Opcode was outside the defined map |

## Verification
The bench drives amounts whose low byte is zero or small while a high bit is set. A design that looks only at the low eight bits would return an unshifted or lightly shifted value where zero, the sign fill or a wrapped rotate is expected. It also tests amounts of exactly 255, 256 and 0, and negative operands under the arithmetic shift. These cases catch a fill taken from the wrong bit, an off-by-one at the excess boundary, or a rotate that flushes to zero. Opcodes just outside the map (0x1a, 0x20), together with idle cycles between operations, show whether a design lets an illegal result through or changes its registered result without a strobe.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned DW  = 256;
  localparam int unsigned AW  = $clog2(DW);
  localparam int unsigned OPW = 8;

  localparam logic [OPW-1:0] OPC_SHL = 8'h1b;
  localparam logic [OPW-1:0] OPC_SHR = 8'h1c;
  localparam logic [OPW-1:0] OPC_SAR = 8'h1d;
  localparam logic [OPW-1:0] OPC_ROL = 8'h1e;
  localparam logic [OPW-1:0] OPC_ROR = 8'h1f;

  typedef enum logic [2:0] {
    K_SHL, K_SHR, K_SAR, K_ROL, K_ROR, K_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     to_left;
    logic     wrap;
    logic     arith;
    logic     legal;
  } op_ctl_t;

  function automatic logic [DW-1:0] bit_rev(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    for (int i = 0; i < DW; i++) y[i] = x[DW-1-i];
    return y;
  endfunction
endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_ctl_t        ctl
);
  always_comb begin
    ctl = '{kind: K_BAD, to_left: 1'b0, wrap: 1'b0, arith: 1'b0, legal: 1'b0};
    unique case (opcode)
      OPC_SHL: ctl = '{kind: K_SHL, to_left: 1'b1, wrap: 1'b0, arith: 1'b0, legal: 1'b1};
      OPC_SHR: ctl = '{kind: K_SHR, to_left: 1'b0, wrap: 1'b0, arith: 1'b0, legal: 1'b1};
      OPC_SAR: ctl = '{kind: K_SAR, to_left: 1'b0, wrap: 1'b0, arith: 1'b1, legal: 1'b1};
      OPC_ROL: ctl = '{kind: K_ROL, to_left: 1'b1, wrap: 1'b1, arith: 1'b0, legal: 1'b1};
      OPC_ROR: ctl = '{kind: K_ROR, to_left: 1'b0, wrap: 1'b1, arith: 1'b0, legal: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/shrot_amount.sv
module shrot_amount #(
  parameter int unsigned DW = 256,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0] index,
  output logic [AW-1:0] amt,
  output logic          excess
);
  assign amt    = index[AW-1:0];
  assign excess = |index[DW-1:AW];
endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int unsigned DW = 256,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  input  logic          wrap,
  input  logic          fill,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    logic [DW-1:0] moved;
    always_comb begin
      if (wrap) moved = {stg[s][SH-1:0], stg[s][DW-1:SH]};
      else      moved = {{SH{fill}}, stg[s][DW-1:SH]};
    end
    assign stg[s+1] = amt[s] ? moved : stg[s];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     opcode,
  input  logic [255:0]   index,
  input  logic [255:0]   value,
  output logic           out_valid,
  output logic [255:0]   result,
  output logic           illegal
);
  op_ctl_t       ctl;
  logic [AW-1:0] amt;
  logic          excess;
  logic          fill;
  logic [DW-1:0] bar_in, bar_out, core_res;
  logic [DW-1:0] res_d, res_q;
  logic          vld_q, ill_d, ill_q;

  shrot_decode u_dec (.opcode(opcode), .ctl(ctl));

  shrot_amount #(.DW(DW), .AW(AW)) u_amt (
    .index(index), .amt(amt), .excess(excess)
  );

  assign fill   = ctl.arith & value[DW-1];
  assign bar_in = ctl.to_left ? bit_rev(value) : value;

  shrot_barrel #(.DW(DW), .AW(AW)) u_bar (
    .din(bar_in), .amt(amt), .wrap(ctl.wrap), .fill(fill), .dout(bar_out)
  );

  assign core_res = ctl.to_left ? bit_rev(bar_out) : bar_out;

  // next-state
  always_comb begin
    ill_d = ~ctl.legal;
    if (!ctl.legal)                res_d = '0;
    else if (excess && !ctl.wrap)  res_d = {DW{fill}};
    else                           res_d = core_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign illegal   = ill_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(illegal))); // R10
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode < OPC_SHL || opcode > OPC_ROR)) |=> (illegal && result == '0)); // R9
  AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && index == '0 && opcode >= OPC_SHL && opcode <= OPC_ROR)
      |=> (result == $past(value))); // R8
  AST_SHIFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OPC_SHL || opcode == OPC_SHR) && index[255:8] != '0)
      |=> (result == '0)); // R5
  AST_SAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_SAR && index[255:8] != '0)
      |=> (result == {256{$past(value[255])}})); // R6
  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OPC_ROL || opcode == OPC_ROR))
      |=> ($countones(result) == $countones($past(value)) && !illegal)); // R7
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   opcode;
  logic [255:0] index, value;
  logic         out_valid, illegal;
  logic [255:0] result;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .index(index), .value(value), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic logic [255:0] model(input logic [7:0] op,
                                          input logic [255:0] idx,
                                          input logic [255:0] v);
    logic big;
    int   n;
    big = (idx >= 256);
    n   = int'(idx[7:0]);
    case (op)
      8'h1b: return big ? '0 : (v << n);
      8'h1c: return big ? '0 : (v >> n);
      8'h1d: return big ? {256{v[255]}} : 256'($signed(v) >>> n);
      8'h1e: return (n == 0) ? v : ((v << n) | (v >> (256 - n)));
      8'h1f: return (n == 0) ? v : ((v >> n) | (v << (256 - n)));
      default: return '0;
    endcase
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] x;
    for (int i = 0; i < 8; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic check(input string req, input logic [255:0] got,
                       input logic [255:0] exp, input logic gi, input logic ei);
    n_vec++;
    if (got !== exp || gi !== ei) begin
      n_bad++;
      $display("FAIL %s: result=%h illegal=%b expected=%h illegal=%b",
               req, got, gi, exp, ei);
    end
  endtask

  task automatic apply(input string req, input logic [7:0] op,
                       input logic [255:0] idx, input logic [255:0] v);
    logic legal;
    legal    = (op >= 8'h1b && op <= 8'h1f);
    in_valid = 1'b1; opcode = op; index = idx; value = v;
    @(negedge clk);
    in_valid = 1'b0;
    if (out_valid !== 1'b1) begin
      n_vec++; n_bad++;
      $display("FAIL R10: out_valid=%b expected=1", out_valid);
    end
    check(req, result, model(op, idx, v), illegal, ~legal);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] neg, pos, hold;
    void'($urandom(32'h5eed_0145));
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; index = '0; value = '0;
    repeat (3) @(negedge clk);
    check("reset", result, '0, illegal, 1'b0);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL reset: out_valid=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    neg = {1'b1, 255'h0123_4567_89ab_cdef};
    pos = {1'b0, 255'h0f0f_00ff_1234};

    // R1, R2, R3, R4 directed
    apply("R2", 8'h1b, 256'd4, 256'h1);
    apply("R2", 8'h1b, 256'd255, 256'h3);
    apply("R3", 8'h1c, 256'd255, neg);
    apply("R4", 8'h1d, 256'd255, neg);
    apply("R4", 8'h1d, 256'd100, neg);
    apply("R4", 8'h1d, 256'd100, pos);
    apply("R1", 8'h1e, 256'd1, neg);
    apply("R1", 8'h1f, 256'd1, 256'h1);
    // R5 excess, including high-only index bits
    apply("R5", 8'h1b, 256'd256, neg);
    apply("R5", 8'h1c, (256'd1 << 128) | 256'd1, neg);
    apply("R5", 8'h1b, {1'b1, 255'd0}, 256'hffff);
    // R6
    apply("R6", 8'h1d, 256'd256, neg);
    apply("R6", 8'h1d, (256'd1 << 200) | 256'd3, neg);
    apply("R6", 8'h1d, 256'd300, pos);
    // R7 wrap
    apply("R7", 8'h1e, (256'd1 << 8) | 256'd5, neg);
    apply("R7", 8'h1f, 256'd256, neg);
    apply("R7", 8'h1f, {256{1'b1}}, 256'h8000_0001);
    // R8
    for (int k = 0; k < 5; k++) apply("R8", 8'h1b + 8'(k), '0, neg);
    // R9
    apply("R9", 8'h1a, 256'd3, neg);
    apply("R9", 8'h20, 256'd3, neg);
    apply("R9", 8'h00, '0, neg);
    // R10: idle cycle holds outputs
    hold = result;
    value = rnd256(); opcode = 8'h1b; index = 256'd1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || result !== hold || illegal !== 1'b1) begin
      n_bad++;
      $display("FAIL R10: out_valid=%b result=%h illegal=%b expected=0 %h 1",
               out_valid, result, illegal, hold);
    end

    // random mix
    for (int t = 0; t < 600; t++) begin
      logic [7:0]   op;
      logic [255:0] idx;
      int           sel;
      sel = int'($urandom % 8);
      op  = (sel < 6) ? 8'h1b + 8'($urandom % 5) : 8'($urandom);
      case ($urandom % 4)
        0:       idx = rnd256();
        1:       idx = (256'd1 << ($urandom % 256)) | 256'($urandom % 256);
        default: idx = 256'($urandom % 256);
      endcase
      apply("R2-R9 random", op, idx, rnd256());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule